// File: doc/BRIEF.md
# Suspend Wake-Up Sequencer

This block decides when a suspended USB peripheral may wake the bus and when it must wake itself. On the device side, software raises a wake request. The sequencer holds off until the bus has sat in the idle J state (D+ high, D- low) for a minimum number of cycles. It then enables the resume K-state drive for a fixed number of cycles and raises a completion interrupt when the drive ends. Software acknowledges the interrupt by writing a one to it. It also drops its request before it can ask again.

The second path is for a host that resumes the bus while the device has stopped its oscillator through the power-down control. When software has armed this path, a high-to-low change on D+ turns the oscillator enable back on. The block then waits for the oscillator to settle. It stops waiting when an external ready input arrives or when a cycle count expires, whichever happens first, and then flags that the host wake is complete. Every duration is a cycle-count parameter. The defaults assume a 12 MHz clock, so simulations can use short values.

Top module: `rwu_wake_seq`

## Requirements
- R1: After reset, resume_drv, rwu_done_irq and host_wake are 0 and osc_en is 1.
- R2: A resume drive starts only once IDLE_CYC consecutive clock samples have shown the J state (bus_dp=1, bus_dm=0). Any sample that is not J restarts the count.
- R3: Once started, resume_drv stays high for exactly RESUME_CYC consecutive cycles.
- R4: rwu_done_irq becomes 1 at the same clock edge at which resume_drv falls.
- R5: After a resume has completed, a held request starts no further drive. A new drive needs sw_rwu_req to be sampled low and then high again.
- R6: rwu_done_irq is cleared by a cycle with irq_wr=1 and irq_wdata=1. A write with irq_wdata=0 leaves it unchanged. If a completion and a clearing write fall in the same cycle, the flag stays set.
- R7: While sw_pwrdown=1 and no drive is in progress, osc_en is 0 and a pending request does not start a drive.
- R8: With osc_en stopped, a 1-to-0 change on bus_dp between two samples raises osc_en on the next edge only if sw_hosc_en=1. With sw_hosc_en=0 the oscillator stays stopped.
- R9: After a host wake restarts the oscillator, host_wake rises on the edge after osc_ready is sampled high, or after STABLE_CYC cycles, whichever comes first.
- R10: While host_wake is 1, osc_en stays 1. Clearing sw_pwrdown returns the block to normal running with host_wake at 0.
- R11: resume_drv is never 1 while osc_en is 0. Power-down requested during a drive takes effect only after the drive ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_dp | input | 1 | Sampled D+ level |
| bus_dm | input | 1 | Sampled D- level |
| sw_rwu_req | input | 1 | Software request to signal remote wake-up |
| sw_hosc_en | input | 1 | Arms the host-activity wake path |
| sw_pwrdown | input | 1 | Software request to stop the oscillator |
| irq_wr | input | 1 | Write strobe for the done flag |
| irq_wdata | input | 1 | Written value; 1 clears the flag |
| osc_ready | input | 1 | Oscillator reports stable clock |
| resume_drv | output | 1 | Enable for the resume K-state driver |
| rwu_done_irq | output | 1 | Remote wake-up complete flag |
| osc_en | output | 1 | Oscillator enable |
| host_wake | output | 1 | Host-initiated wake complete, clock stable |

## Verification
A wrong idle count appears at resume_drv. The drive either starts before the IDLE_CYC-th J sample or fails to start at it, and the error shows on the first cycle of the drive. A wrong drive counter shows a pulse whose length is off, and the completion flag moves with it. A fault in the oscillator state shows at osc_en or host_wake within one cycle of the D+ edge, of the ready input, or of the power-down change that should have moved it. A cycle-accurate model in the bench is compared against all four outputs on every clock, so any of these faults is caught in the cycle where it first becomes visible.

// File: rtl/rwu_wake_pkg.sv
package rwu_wake_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DRIVE = 2'd1,
        RS_DONE  = 2'd2
    } rs_state_t;

    typedef enum logic [1:0] {
        OS_RUN   = 2'd0,
        OS_STOP  = 2'd1,
        OS_START = 2'd2,
        OS_WOKE  = 2'd3
    } os_state_t;

    typedef struct packed {
        logic dp;
        logic dm;
    } bus_lvl_t;

    typedef struct packed {
        logic req;
        logic hosc_en;
        logic pwrdown;
    } sw_ctl_t;

    function automatic logic bus_is_j(bus_lvl_t b);
        return b.dp & ~b.dm;
    endfunction

endpackage

// File: rtl/rwu_idle_timer.sv
module rwu_idle_timer
    import rwu_wake_pkg::*;
#(
    parameter int IDLE_CYC = 60000
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_lvl_t bus,
    output logic     idle_ok
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_CYC);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (!bus_is_j(bus)) begin
            idle_cnt <= '0;
        end else if (idle_cnt != IDLE_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign idle_ok = (idle_cnt == IDLE_MAX);

    // R2: a non-J sample leaves the bus not-idle on the next cycle
    p_idle_restart_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_is_j(bus) |=> !idle_ok);

endmodule

// File: rtl/rwu_resume_fsm.sv
module rwu_resume_fsm
    import rwu_wake_pkg::*;
#(
    parameter int RESUME_CYC = 120000
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic idle_ok,
    input  logic clk_ok,
    input  logic irq_wr,
    input  logic irq_wdata,
    output logic drv,
    output logic busy,
    output logic irq
);
    localparam int DW = $clog2(RESUME_CYC + 1);
    localparam logic [DW-1:0] DRV_LAST = DW'(RESUME_CYC - 1);

    rs_state_t     st;
    logic [DW-1:0] dcnt;
    logic          start, finish;

    assign start  = (st == RS_IDLE) && req && idle_ok && clk_ok;
    assign finish = (st == RS_DRIVE) && (dcnt == DRV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RS_IDLE;
            dcnt <= '0;
        end else begin
            case (st)
                RS_IDLE: begin
                    dcnt <= '0;
                    if (start) st <= RS_DRIVE;
                end
                RS_DRIVE: begin
                    dcnt <= dcnt + 1'b1;
                    if (finish) st <= RS_DONE;
                end
                RS_DONE: begin
                    dcnt <= '0;
                    if (!req) st <= RS_IDLE;
                end
                default: st <= RS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    irq <= 1'b0;
        else if (finish)            irq <= 1'b1;
        else if (irq_wr && irq_wdata) irq <= 1'b0;
    end

    assign drv  = (st == RS_DRIVE);
    assign busy = drv;

    // R2: a drive begins only with idle bus, running clock and a request
    p_start_gated_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(drv) |-> $past(idle_ok && clk_ok && req));
    // R3: drive holds until its final count
    p_drv_len_r3: assert property (@(posedge clk) disable iff (rst)
        (drv && dcnt != DRV_LAST) |=> drv);
    // R4: end of drive raises the flag
    p_irq_on_end_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(drv) |-> irq);
    // R5: a held request after completion starts nothing
    p_no_retrigger_r5: assert property (@(posedge clk) disable iff (rst)
        (st == RS_DONE && req) |=> !drv);

endmodule

// File: rtl/rwu_osc_ctrl.sv
module rwu_osc_ctrl
    import rwu_wake_pkg::*;
#(
    parameter int STABLE_CYC = 24000
) (
    input  logic clk,
    input  logic rst,
    input  logic dp,
    input  logic pwrdown,
    input  logic hosc_en,
    input  logic drv_busy,
    input  logic osc_ready,
    output logic osc_en,
    output logic osc_run,
    output logic host_wake
);
    localparam int SW = $clog2(STABLE_CYC + 1);
    localparam logic [SW-1:0] STAB_LAST = SW'(STABLE_CYC - 1);

    os_state_t     os;
    logic [SW-1:0] scnt;
    logic          dp_q, dp_fall;

    assign dp_fall = dp_q & ~dp;

    always_ff @(posedge clk) begin
        if (rst) dp_q <= 1'b0;
        else     dp_q <= dp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            os   <= OS_RUN;
            scnt <= '0;
        end else begin
            case (os)
                OS_RUN: begin
                    scnt <= '0;
                    if (pwrdown && !drv_busy) os <= OS_STOP;
                end
                OS_STOP: begin
                    scnt <= '0;
                    if (!pwrdown)                os <= OS_RUN;
                    else if (hosc_en && dp_fall) os <= OS_START;
                end
                OS_START: begin
                    scnt <= scnt + 1'b1;
                    if (osc_ready || scnt == STAB_LAST) os <= OS_WOKE;
                end
                OS_WOKE: begin
                    scnt <= '0;
                    if (!pwrdown) os <= OS_RUN;
                end
                default: os <= OS_RUN;
            endcase
        end
    end

    assign osc_en    = (os != OS_STOP);
    assign osc_run   = (os == OS_RUN);
    assign host_wake = (os == OS_WOKE);

    // R8: unarmed wake path ignores bus activity
    p_unarmed_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (os == OS_STOP && pwrdown && !hosc_en) |=> (os == OS_STOP));
    // R9: ready input ends the wait at once
    p_ready_wakes_r9: assert property (@(posedge clk) disable iff (rst)
        (os == OS_START && osc_ready) |=> host_wake);
    // R11: an active drive keeps the oscillator running
    p_hold_for_drive_r11: assert property (@(posedge clk) disable iff (rst)
        (os == OS_RUN && drv_busy) |=> osc_en);
    // R10: after host wake the clock stays on until power-down clears
    p_woke_keeps_clk_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wake && pwrdown) |=> osc_en);

endmodule

// File: rtl/rwu_wake_seq.sv
module rwu_wake_seq
    import rwu_wake_pkg::*;
#(
    parameter int IDLE_CYC   = 60000,   // 5 ms at 12 MHz
    parameter int RESUME_CYC = 120000,  // 10 ms at 12 MHz
    parameter int STABLE_CYC = 24000    // 2 ms at 12 MHz
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_dp,
    input  logic bus_dm,
    input  logic sw_rwu_req,
    input  logic sw_hosc_en,
    input  logic sw_pwrdown,
    input  logic irq_wr,
    input  logic irq_wdata,
    input  logic osc_ready,
    output logic resume_drv,
    output logic rwu_done_irq,
    output logic osc_en,
    output logic host_wake
);
    bus_lvl_t bus;
    sw_ctl_t  ctl;
    logic     idle_ok, drv_busy, osc_run, clk_ok;

    assign bus    = '{dp: bus_dp, dm: bus_dm};
    assign ctl    = '{req: sw_rwu_req, hosc_en: sw_hosc_en, pwrdown: sw_pwrdown};
    assign clk_ok = osc_run & ~ctl.pwrdown;

    rwu_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .idle_ok (idle_ok)
    );

    rwu_resume_fsm #(.RESUME_CYC(RESUME_CYC)) u_resume (
        .clk       (clk),
        .rst       (rst),
        .req       (ctl.req),
        .idle_ok   (idle_ok),
        .clk_ok    (clk_ok),
        .irq_wr    (irq_wr),
        .irq_wdata (irq_wdata),
        .drv       (resume_drv),
        .busy      (drv_busy),
        .irq       (rwu_done_irq)
    );

    rwu_osc_ctrl #(.STABLE_CYC(STABLE_CYC)) u_osc (
        .clk       (clk),
        .rst       (rst),
        .dp        (bus.dp),
        .pwrdown   (ctl.pwrdown),
        .hosc_en   (ctl.hosc_en),
        .drv_busy  (drv_busy),
        .osc_ready (osc_ready),
        .osc_en    (osc_en),
        .osc_run   (osc_run),
        .host_wake (host_wake)
    );

    // R11: resume signalling never runs with the oscillator stopped
    p_drv_clocked_r11: assert property (@(posedge clk) disable iff (rst)
        resume_drv |-> osc_en);
    // R6: writing zero leaves the flag set
    p_w0_noeffect_r6: assert property (@(posedge clk) disable iff (rst)
        (rwu_done_irq && irq_wr && !irq_wdata) |=> rwu_done_irq);

endmodule

// File: tb/rwu_wake_seq_tb.sv
module rwu_wake_seq_tb;
    localparam int IDLE   = 20;
    localparam int RESUME = 8;
    localparam int STABLE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dp = 1'b1, dm = 1'b0, req = 1'b0, hosc = 1'b0, pd = 1'b0;
    logic wr = 1'b0, wd = 1'b0, rdy = 1'b0;
    logic resume_drv, rwu_done_irq, osc_en, host_wake;

    always #10 clk = ~clk;

    rwu_wake_seq #(.IDLE_CYC(IDLE), .RESUME_CYC(RESUME), .STABLE_CYC(STABLE)) u_dut (
        .clk(clk), .rst(rst), .bus_dp(dp), .bus_dm(dm), .sw_rwu_req(req),
        .sw_hosc_en(hosc), .sw_pwrdown(pd), .irq_wr(wr), .irq_wdata(wd),
        .osc_ready(rdy), .resume_drv(resume_drv), .rwu_done_irq(rwu_done_irq),
        .osc_en(osc_en), .host_wake(host_wake)
    );

    int vectors = 0, fails = 0;
    string tag = "R1";

    // reference model: behavioural, integer-based
    int m_idle = 0, m_phase = 0, m_drv_left = 0, m_os = 0, m_wait = 0;
    bit m_irq = 0, m_prev_dp = 0;

    task automatic model_edge();
        bit jnow, fell, fin;
        int n_idle, n_phase, n_left, n_os, n_wait;
        if (rst) begin
            m_idle = 0; m_phase = 0; m_drv_left = 0; m_os = 0; m_wait = 0;
            m_irq = 0; m_prev_dp = 0;
            return;
        end
        jnow = dp && !dm;
        fell = m_prev_dp && !dp;
        n_idle = !jnow ? 0 : (m_idle < IDLE ? m_idle + 1 : IDLE);
        n_phase = m_phase; n_left = m_drv_left; fin = 0;
        if (m_phase == 0 && req && m_idle >= IDLE && !pd && m_os == 0) begin
            n_phase = 1; n_left = RESUME;
        end else if (m_phase == 1) begin
            n_left = m_drv_left - 1;
            if (n_left == 0) begin n_phase = 2; fin = 1; end
        end else if (m_phase == 2 && !req) n_phase = 0;
        n_os = m_os; n_wait = m_wait;
        case (m_os)
            0: if (pd && m_phase != 1) n_os = 1;
            1: if (!pd) n_os = 0; else if (hosc && fell) begin n_os = 2; n_wait = 0; end
            2: begin n_wait = m_wait + 1; if (rdy || n_wait >= STABLE) n_os = 3; end
            default: if (!pd) n_os = 0;
        endcase
        if (fin) m_irq = 1; else if (wr && wd) m_irq = 0;
        m_idle = n_idle; m_phase = n_phase; m_drv_left = n_left;
        m_os = n_os; m_wait = n_wait; m_prev_dp = dp;
    endtask

    task automatic cmp(string nm, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            #2;
            cmp("resume_drv", resume_drv, m_phase == 1);
            cmp("rwu_done_irq", rwu_done_irq, m_irq);
            cmp("osc_en", osc_en, m_os != 1);
            cmp("host_wake", host_wake, m_os == 3);
        end
    endtask

    task automatic fall_dp();
        dp = 1'b0; cyc(1); dp = 1'b1; cyc(1);
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        tag = "R1"; cyc(3); rst = 1'b0; cyc(2);
        // R2: idle count broken by SE0, then full idle with request
        tag = "R2"; cyc(10); dp = 1'b0; cyc(1); dp = 1'b1; req = 1'b1; cyc(22);
        tag = "R3"; cyc(6);
        tag = "R4"; cyc(3);
        // R5: held request does not retrigger; drop and re-raise does
        tag = "R5"; cyc(12); req = 1'b0; cyc(2); req = 1'b1; cyc(3);
        // R6: write zero keeps flag, write one clears, set wins over clear
        tag = "R6"; wr = 1'b1; wd = 1'b0; cyc(2); wd = 1'b1; cyc(1);
        cyc(10); wr = 1'b0; wd = 1'b0; cyc(2);
        wr = 1'b1; wd = 1'b1; cyc(1); wr = 1'b0; wd = 1'b0;
        // R7: power-down stops oscillator, request waits
        tag = "R7"; req = 1'b0; cyc(2); pd = 1'b1; req = 1'b1; cyc(15);
        // R8: unarmed edge ignored, armed edge restarts clock
        tag = "R8"; fall_dp(); cyc(3); hosc = 1'b1; fall_dp();
        tag = "R9"; cyc(8);
        tag = "R10"; cyc(2); pd = 1'b0; cyc(3);
        // R9: ready shortens the wait
        tag = "R9"; req = 1'b0; pd = 1'b1; cyc(2); fall_dp(); rdy = 1'b1; cyc(3); rdy = 1'b0;
        tag = "R10"; pd = 1'b0; cyc(3);
        // R11: power-down during drive deferred until drive ends
        tag = "R11"; req = 1'b1; cyc(IDLE + 3); pd = 1'b1; cyc(12); pd = 1'b0; req = 1'b0; cyc(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule